// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus (clock line plus open-drain data line) that lets an external controller read and write a bank of eight 8-bit configuration registers. The bus lines are sampled by the much faster system clock. They pass through two-flop synchronizers, and edge detectors find clock edges and start and stop conditions. The data line is driven only by pulling it low, through an output-enable signal. All register contents leave the block as one flat parallel bus for the surrounding logic.

The controller opens each transfer with the write address. The command byte then picks one of two modes. In indexed mode, a single register is reached at the offset carried in the command. In counted block mode, the controller starts at register 0 and walks upward. A block write carries a byte count ahead of the data. A block read returns a byte count ahead of the data. Reads always pass through a repeated start and the read address. Every register has a defined reset value, so the bus never has to be used.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, register 0 holds 0x8E, registers 1 to 7 hold 0x00, and the data line is released (sda_oe_o = 0).
- R2: The slave acknowledges the address byte 0xD4 (7-bit address 0x6A, write) and 0xD5 (read). Any other address byte is not acknowledged, and every following byte is ignored without acknowledge until the next start or stop.
- R3: A command byte with bit 7 = 1 selects indexed mode with offset = bits 6:0. The next data byte is acknowledged and stored at that offset.
- R4: In indexed mode, a repeated start followed by 0xD5 makes the slave shift out the register at the commanded offset, MSB first.
- R5: A command byte with bit 7 = 0 selects block mode, and bits 6:0 are not used. The next byte is a count: it is acknowledged and does not limit the transfer. The data bytes that follow go into registers 0, 1, 2 and onward.
- R6: A block-mode read first returns the count value 8, then registers 0, 1 and onward, for as long as the controller acknowledges. After the controller's not-acknowledge, the slave releases the data line and sends nothing more.
- R7: A stop after any complete byte ends the transfer. Bytes already written stay in place.
- R8: Bit 3 of register 0 always reads 1. Writing 0 to it has no effect.
- R9: A byte write to an offset of 8 or more is acknowledged and discarded. A byte read from such an offset returns 0x00.
- R10: The slave acknowledges by pulling the data line low for the ninth clock. The slave changes sda_oe_o only while the bus clock is low.
- R11: Register outputs change only through an accepted data byte. A stop condition releases the data line by the following system clock.
- R12: A falling data line while the bus clock is high starts a new address phase, even in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | High pulls the data line low |
| cfg_o | output | 64 | Register contents, register n at bits 8n+7:8n |

## Verification
The bench drives complete bus transactions and checks every acknowledge bit against the expected value. A reference model of the bank is compared with cfg_o on every system clock while the bus clock is high. The bench targets the cases that break easily:
- A block read must return the count before the data. A design that skips it would return register 0 where 8 belongs.
- A mismatched address must be refused. A design that does not refuse it would acknowledge the bytes after it and write stray data.
- A stop after two of five announced block bytes must leave only two registers changed.
- A write of 0 to the reserved bit must not clear it.
- A repeated start in the middle of a write must restart the address phase. A design that does not restart it would take the address byte as data.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_CNT, ST_WR, ST_RD, ST_WAIT
  } st_e;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned BIT_CNT_W = 4;
  localparam int unsigned PTR_W     = 8;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // STAGES sync flops plus one history flop per line
  logic [STAGES:0] scl_q, sda_q;
  logic scl_s, scl_p, sda_s, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  assign scl_s = scl_q[STAGES-1];
  assign scl_p = scl_q[STAGES];
  assign sda_s = sda_q[STAGES-1];
  assign sda_p = sda_q[STAGES];

  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs #(
  parameter int unsigned NREG = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned AW   = 8,
  parameter logic [NREG*DW-1:0] RST_VAL  = '0,
  parameter logic [NREG*DW-1:0] FIX_MASK = '0,
  parameter logic [NREG*DW-1:0] FIX_VAL  = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [DW-1:0]      rd_data_o,
  output logic [NREG*DW-1:0] regs_o
);
  localparam int unsigned IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DW-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] MSK = FIX_MASK[i*DW +: DW];
    localparam logic [DW-1:0] FIX = FIX_VAL[i*DW +: DW];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        q[i] <= RST_VAL[i*DW +: DW];
      else if (wr_en_i && wr_addr_i == AW'(i))
        q[i] <= (wr_data_i & ~MSK) | (FIX & MSK);
    end
    assign regs_o[i*DW +: DW] = q[i];
  end

  assign rd_data_o = (rd_addr_i < AW'(NREG)) ? q[rd_addr_i[IW-1:0]] : '0;
endmodule

// File: rtl/smb_cfg_fsm.sv
module smb_cfg_fsm
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h6A,
  parameter int unsigned NREG     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [PTR_W-1:0]  rd_addr_o,
  output logic              wr_en_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_oe_o
);
  st_e                 st;
  logic [BIT_CNT_W-1:0] bit_cnt;
  logic [BYTE_W-1:0]   rx, tx, tx_next;
  logic [PTR_W-1:0]    ptr;
  logic [6:0]          cmd_off;
  logic                byte_mode, need_cnt, nack, oe;

  assign tx_next   = need_cnt ? BYTE_W'(NREG) : rd_data_i;
  assign rd_addr_o = ptr;
  assign sda_oe_o  = oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      bit_cnt   <= '0;
      rx        <= '0;
      tx        <= '0;
      ptr       <= '0;
      cmd_off   <= '0;
      byte_mode <= 1'b0;
      need_cnt  <= 1'b0;
      nack      <= 1'b0;
      oe        <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_i) begin
        st      <= ST_IDLE;
        oe      <= 1'b0;
        bit_cnt <= '0;
      end else if (start_i) begin
        st      <= ST_ADDR;
        oe      <= 1'b0;
        bit_cnt <= '0;
        nack    <= 1'b0;
      end else if (scl_rise_i) begin
        if (bit_cnt < BIT_CNT_W'(8)) rx <= {rx[BYTE_W-2:0], sda_s_i};
        else if (st == ST_RD)        nack <= sda_s_i;
        bit_cnt <= bit_cnt + 1'b1;
      end else if (scl_fall_i) begin
        if (bit_cnt == BIT_CNT_W'(8)) begin
          // byte complete: decide acknowledge
          unique case (st)
            ST_ADDR: begin
              if (rx == {DEV_ADDR, 1'b0}) begin
                oe <= 1'b1;
                st <= ST_CMD;
              end else if (rx == {DEV_ADDR, 1'b1}) begin
                oe       <= 1'b1;
                st       <= ST_RD;
                need_cnt <= ~byte_mode;
                ptr      <= byte_mode ? {1'b0, cmd_off} : '0;
              end else begin
                st <= ST_WAIT;
              end
            end
            ST_CMD: begin
              oe        <= 1'b1;
              byte_mode <= rx[7];
              cmd_off   <= rx[6:0];
              ptr       <= rx[7] ? {1'b0, rx[6:0]} : '0;
              st        <= rx[7] ? ST_WR : ST_CNT;
            end
            ST_CNT: begin
              oe <= 1'b1;
              st <= ST_WR;
            end
            ST_WR: begin
              oe        <= 1'b1;
              wr_en_o   <= 1'b1;
              wr_addr_o <= ptr;
              wr_data_o <= rx;
              if (ptr != '1) ptr <= ptr + 1'b1;
            end
            ST_RD:   oe <= 1'b0;  // controller drives its acknowledge
            default: ;
          endcase
        end else if (bit_cnt == BIT_CNT_W'(9)) begin
          bit_cnt <= '0;
          oe      <= 1'b0;
          if (st == ST_RD) begin
            if (nack) begin
              st <= ST_WAIT;
            end else begin
              tx <= tx_next;
              oe <= ~tx_next[7];
              if (need_cnt)        need_cnt <= 1'b0;
              else if (ptr != '1)  ptr      <= ptr + 1'b1;
            end
          end
        end else if (st == ST_RD && bit_cnt != '0) begin
          oe <= ~tx[6];
          tx <= {tx[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h6A,
  parameter int unsigned NREG     = 8,
  parameter int unsigned STAGES   = 2,
  parameter logic [NREG*BYTE_W-1:0] RST_VAL  = 64'h0000_0000_0000_008E,
  parameter logic [NREG*BYTE_W-1:0] FIX_MASK = 64'h0000_0000_0000_0008,
  parameter logic [NREG*BYTE_W-1:0] FIX_VAL  = 64'h0000_0000_0000_0008
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  output logic [NREG*BYTE_W-1:0] cfg_o
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  smb_line_sync #(.STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_cfg_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_fsm (
    .clk_i, .rst_ni,
    .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sda_oe_o(sda_oe_o)
  );

  smb_cfg_regs #(
    .NREG(NREG), .DW(BYTE_W), .AW(PTR_W),
    .RST_VAL(RST_VAL), .FIX_MASK(FIX_MASK), .FIX_VAL(FIX_VAL)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .regs_o(cfg_o)
  );
endmodule

// File: rtl/smb_cfg_chk.sv
module smb_cfg_chk #(
  parameter int unsigned NREG = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic [NREG*8-1:0] cfg_o,
  input logic              stop_det,
  input logic              wr_en,
  input logic [7:0]        wr_addr
);
  AST_RSV_BIT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o[3]); // R8
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i); // R10
  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o); // R11
  AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o != $past(cfg_o)) |-> $past(wr_en)); // R11
  AST_OOR_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr >= 8'(NREG)) |=> $stable(cfg_o)); // R9
endmodule

bind smb_cfg_slave smb_cfg_chk #(.NREG(NREG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .cfg_o(cfg_o), .stop_det(stop_det), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/sim_smb_cfg_slave.sv
`timescale 1ns/1ps
module sim_smb_cfg_slave;
  localparam int Q = 6;  // system clocks per quarter bus bit

  logic clk = 1'b0, rst_ni = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [63:0] cfg;
  wire  sda_line = sda_oe ? 1'b0 : sda_m;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [7:0]  mdl [8];
  logic [63:0] mdl_vec;

  always #5 clk = ~clk;

  smb_cfg_slave u0 (.clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_line),
                    .sda_oe_o(sda_oe), .cfg_o(cfg));

  always_comb for (int i = 0; i < 8; i++) mdl_vec[i*8 +: 8] = mdl[i];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // reference model compared every clock while the bus clock is high (R3 R5 R7 R11)
  always @(negedge clk) if (rst_ni && scl && !done) chk("R11 model", cfg, mdl_vec);

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic mdl_wr(input int idx, input logic [7:0] b);
    if (idx >= 0 && idx < 8) mdl[idx] = (idx == 0) ? (b | 8'h08) : b;
  endtask

  task automatic bus_start;  // R12
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send(input logic [7:0] b, input logic exp_ack, input string req, input int wr_idx);
    logic ack;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    end
    sda_m = 1'b1;
    mdl_wr(wr_idx, b);
    wq(Q); scl = 1'b1; wq(Q); ack = sda_line; wq(Q); scl = 1'b0; wq(Q);
    chk(req, ack, exp_ack);
  endtask

  task automatic recv(output logic [7:0] b, input logic give_ack);
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl = 1'b0; wq(Q);
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic byte_wr(input logic [6:0] off, input logic [7:0] d);
    bus_start;
    send(8'hD4, 1'b0, "R2 write addr ack", -1);
    send({1'b1, off}, 1'b0, "R3 cmd ack", -1);
    send(d, 1'b0, "R3 data ack", int'(off));
    bus_stop;
  endtask

  task automatic byte_rd(input logic [6:0] off, output logic [7:0] d);
    bus_start;
    send(8'hD4, 1'b0, "R2 write addr ack", -1);
    send({1'b1, off}, 1'b0, "R3 cmd ack", -1);
    bus_start;
    send(8'hD5, 1'b0, "R2 read addr ack", -1);
    recv(d, 1'b0);
    chk("R10 released after nack", sda_oe, 1'b0);
    bus_stop;
  endtask

  initial begin
    logic [7:0] d;
    mdl[0] = 8'h8E;
    for (int i = 1; i < 8; i++) mdl[i] = 8'h00;
    wq(5); rst_ni = 1'b1; wq(3);
    chk("R1 reset regs", cfg, 64'h0000_0000_0000_008E);
    chk("R1 reset oe", sda_oe, 1'b0);

    // indexed write and read
    byte_wr(7'd2, 8'h5A);
    chk("R3 reg2", cfg[23:16], 8'h5A);
    byte_rd(7'd2, d);
    chk("R4 read reg2", d, 8'h5A);
    byte_wr(7'd7, 8'hC3);
    byte_rd(7'd7, d);
    chk("R4 read reg7", d, 8'hC3);

    // reserved bit
    byte_wr(7'd0, 8'h00);
    byte_rd(7'd0, d);
    chk("R8 reg0 rsv bit", d, 8'h08);

    // out of range
    byte_wr(7'h10, 8'hFF);
    chk("R9 oor write discarded", cfg, mdl_vec);
    byte_rd(7'h10, d);
    chk("R9 oor read zero", d, 8'h00);

    // block write: count 3, bytes to regs 0..2
    bus_start;
    send(8'hD4, 1'b0, "R2 addr", -1);
    send(8'h00, 1'b0, "R5 block cmd ack", -1);
    send(8'h03, 1'b0, "R5 count ack", -1);
    send(8'hA1, 1'b0, "R5 data0 ack", 0);
    send(8'hB2, 1'b0, "R5 data1 ack", 1);
    send(8'hC3, 1'b0, "R5 data2 ack", 2);
    bus_stop;
    chk("R5 reg0..2", cfg[23:0], 24'hC3B2A9);

    // block read: count then regs 0..3
    bus_start;
    send(8'hD4, 1'b0, "R2 addr", -1);
    send(8'h00, 1'b0, "R5 block cmd", -1);
    bus_start;
    send(8'hD5, 1'b0, "R2 read addr", -1);
    recv(d, 1'b1);
    chk("R6 count byte", d, 8'd8);
    for (int i = 0; i < 4; i++) begin
      recv(d, i != 3);
      chk("R6 block data", d, mdl[i]);
    end
    chk("R6 released after nack", sda_oe, 1'b0);
    wq(Q); scl = 1'b1; wq(Q);
    chk("R6 nothing after nack", sda_oe, 1'b0);
    scl = 1'b0; wq(Q);
    bus_stop;

    // block write stopped early: count 5, only 2 bytes
    bus_start;
    send(8'hD4, 1'b0, "R2 addr", -1);
    send(8'h00, 1'b0, "R5 block cmd", -1);
    send(8'h05, 1'b0, "R7 count", -1);
    send(8'h11, 1'b0, "R7 data0", 0);
    send(8'h22, 1'b0, "R7 data1", 1);
    bus_stop;
    chk("R7 partial block", cfg, mdl_vec);
    chk("R7 reg2 kept", cfg[23:16], 8'hC3);
    chk("R11 oe after stop", sda_oe, 1'b0);

    // wrong address ignored
    bus_start;
    send(8'hA0, 1'b1, "R2 mismatch nack", -1);
    send(8'h81, 1'b1, "R2 ignored cmd", -1);
    send(8'hEE, 1'b1, "R2 ignored data", -1);
    bus_stop;
    chk("R2 regs unchanged", cfg, mdl_vec);

    // repeated start in the middle of a write
    bus_start;
    send(8'hD4, 1'b0, "R12 addr", -1);
    send(8'h83, 1'b0, "R12 cmd", -1);
    bus_start;
    send(8'hD4, 1'b0, "R12 addr after restart", -1);
    send(8'h84, 1'b0, "R12 cmd after restart", -1);
    send(8'h77, 1'b0, "R12 data", 4);
    bus_stop;
    chk("R12 reg4", cfg[39:32], 8'h77);
    chk("R12 reg3 untouched", cfg[31:24], 8'h00);
    chk("R10 idle release", sda_oe, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule